// File: doc/BRIEF.md
# Interrupt Entry Stack Frame Sequencer

This block performs the register and memory side of entering a handler once an interrupt or exception has been accepted. A one-cycle `start` presents the vector number, the gate that was selected for it (interrupt or trap, target code selector, entry offset, target privilege level), the architectural state being left (privilege level, stack selector and pointer, flags, code selector, instruction pointer) and an optional error code. The sequencer writes a return frame onto a stack through a 32-bit memory write port with a valid/ready handshake. It then presents the handler's code selector, instruction pointer, stack selector and pointer, privilege level and the adjusted flags, and pulses `done`.

A target at the same privilege level reuses the current stack. A more privileged target (numerically lower level) takes a fresh stack from a small bank that holds one selector/pointer pair per privilege level, and the old stack selector and pointer are saved at the top of the new frame. The bank is loaded through its own write port. A request for a reserved vector, or for a less privileged target, is refused: no memory write, a one-cycle `err`.

Top module: `intr_frame_seq`

## Requirements
- R1: After reset `busy`, `done`, `err` and `mem_valid` are 0 and all `new_*` outputs are 0.
- R2: When `gate_pl` equals `cur_pl`, the frame goes onto the current stack: `cur_flags`, then `cur_cs` zero-extended to 32 bits, then `cur_ip`, at addresses `cur_sp-4`, `cur_sp-8`, `cur_sp-12`.
- R3: When `has_err` is 1, `err_code` is written as the last word of the frame, 4 bytes below the instruction pointer word; when it is 0, no error-code word is written.
- R4: When `gate_pl` is numerically lower than `cur_pl`, the stack pointer starts at the bank entry for `gate_pl`, and the frame is `cur_ss` (zero-extended), `cur_sp`, `cur_flags`, `cur_cs`, `cur_ip` and optionally the error code, each word 4 bytes below the previous one.
- R5: Exactly one word is written for each cycle with `mem_valid` and `mem_ready` both 1; while `mem_valid` is 1 and `mem_ready` is 0, `mem_addr` and `mem_data` hold their values.
- R6: `done` is a one-cycle pulse in the cycle after the last word's handshake; from that cycle `new_cs`=`gate_sel`, `new_ip`=`gate_off`, `new_pl`=`gate_pl`, `new_ss` is the stack selector in use and `new_sp` is the address of the last word written.
- R7: With `gate_intr`=1 (interrupt gate), `new_flags` equals the saved flags with bit 9 cleared; with `gate_intr`=0 (trap gate), `new_flags` equals the saved flags. The flags word written to memory is always the unmodified `cur_flags`.
- R8: A request with vector 15 or 20 to 31 writes nothing, leaves `busy` at 0 and the `new_*` outputs unchanged, and raises `err` for exactly one cycle; vectors 0-14, 16-19 and 32-255 are accepted.
- R9: A request with `gate_pl` numerically greater than `cur_pl` is refused in the same way as R8.
- R10: A `start` while `busy` is 1 is ignored: the frame in progress completes unchanged and `err` stays 0.
- R11: A bank write (`bank_we`=1) to level `bank_lvl` sets the stack selector and pointer used by later requests that switch to that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled while idle |
| vector | input | 8 | Vector number |
| gate_intr | input | 1 | 1 = interrupt gate, 0 = trap gate |
| gate_sel | input | 16 | Handler code selector |
| gate_off | input | 32 | Handler entry offset |
| gate_pl | input | 2 | Handler privilege level |
| has_err | input | 1 | Error code present |
| err_code | input | 32 | Error code |
| cur_pl | input | 2 | Current privilege level |
| cur_ss | input | 16 | Current stack selector |
| cur_sp | input | 32 | Current stack pointer |
| cur_flags | input | 32 | Current flags word |
| cur_cs | input | 16 | Current code selector |
| cur_ip | input | 32 | Current instruction pointer |
| bank_we | input | 1 | Stack bank write enable |
| bank_lvl | input | 2 | Stack bank entry written |
| bank_ss | input | 16 | Stack selector for that entry |
| bank_sp | input | 32 | Stack pointer for that entry |
| mem_valid | output | 1 | Write request |
| mem_addr | output | 32 | Write address |
| mem_data | output | 32 | Write data |
| mem_ready | input | 1 | Write accepted |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Handler state loaded (one cycle) |
| err | output | 1 | Request refused (one cycle) |
| new_cs | output | 16 | Handler code selector |
| new_ip | output | 32 | Handler instruction pointer |
| new_ss | output | 16 | Stack selector after entry |
| new_sp | output | 32 | Stack pointer after entry |
| new_flags | output | 32 | Flags after entry |
| new_pl | output | 2 | Privilege level after entry |

## Verification
The assertions assume that the memory side never withdraws `mem_ready` in a way that matters to the block and that a request's inputs are valid in the cycle `start` is high; they do not assume the inputs stay stable afterwards, since the block captures them. The address-step property presumes the stack pointer does not wrap below zero during a frame, so every stimulus uses stack pointers far above the frame size. The bench only drives `mem_ready` between clock edges and raises `start` during a busy frame with a reserved vector, so that a wrongly accepted request would show up as `err`.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SLOT_W = 3;

  typedef enum logic [SLOT_W-1:0] {
    SL_OSS = 3'd0,
    SL_OSP = 3'd1,
    SL_FL  = 3'd2,
    SL_CS  = 3'd3,
    SL_IP  = 3'd4,
    SL_EC  = 3'd5
  } slot_e;

  function automatic logic [WORD_W-1:0] push_addr(input logic [WORD_W-1:0] sp);
    return sp - WORD_W'(4);
  endfunction

  function automatic logic vec_reserved(input logic [7:0] v);
    return (v == 8'd15) || (v >= 8'd20 && v <= 8'd31);
  endfunction

  function automatic logic [WORD_W-1:0] clear_bit(input logic [WORD_W-1:0] w,
                                                  input int unsigned pos);
    logic [WORD_W-1:0] r;
    r = w;
    r[pos] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/intr_gate_check.sv
module intr_gate_check #(
  parameter int unsigned PL_W  = 2,
  parameter int unsigned VEC_W = 8
) (
  input  logic [VEC_W-1:0] vector,
  input  logic [PL_W-1:0]  cur_pl,
  input  logic [PL_W-1:0]  tgt_pl,
  output logic             reject,
  output logic             need_switch
);
  import intr_pkg::*;
  logic bad_vec;
  logic bad_pl;

  always_comb begin
    bad_vec     = vec_reserved(8'(vector));
    bad_pl      = tgt_pl > cur_pl;
    reject      = bad_vec || bad_pl;
    need_switch = tgt_pl < cur_pl;
  end
endmodule

// File: rtl/intr_stack_bank.sv
module intr_stack_bank #(
  parameter int unsigned PL_W   = 2,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PL_W-1:0]   wlvl,
  input  logic [SEL_W-1:0]  wss,
  input  logic [WORD_W-1:0] wsp,
  input  logic [PL_W-1:0]   rlvl,
  output logic [SEL_W-1:0]  rss,
  output logic [WORD_W-1:0] rsp
);
  localparam int unsigned NUM_PL = 1 << PL_W;

  logic [SEL_W-1:0]  ss_q [NUM_PL];
  logic [WORD_W-1:0] sp_q [NUM_PL];

  for (genvar g = 0; g < NUM_PL; g++) begin : g_lvl
    logic hit;
    assign hit = we && (wlvl == PL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ss_q[g] <= '0;
        sp_q[g] <= '0;
      end else if (hit) begin
        ss_q[g] <= wss;
        sp_q[g] <= wsp;
      end
    end
  end

  assign rss = ss_q[rlvl];
  assign rsp = sp_q[rlvl];

  // R11
  bank_write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rlvl != $past(wlvl)) || (rss == $past(wss) && rsp == $past(wsp)));
endmodule

// File: rtl/intr_frame_fsm.sv
module intr_frame_fsm #(
  parameter int unsigned PL_W   = 2,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IF_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              reject,
  input  logic              need_switch,
  input  logic              gate_intr,
  input  logic [SEL_W-1:0]  gate_sel,
  input  logic [WORD_W-1:0] gate_off,
  input  logic [PL_W-1:0]   gate_pl,
  input  logic              has_err,
  input  logic [WORD_W-1:0] err_code,
  input  logic [SEL_W-1:0]  cur_ss,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic [WORD_W-1:0] cur_flags,
  input  logic [SEL_W-1:0]  cur_cs,
  input  logic [WORD_W-1:0] cur_ip,
  input  logic [SEL_W-1:0]  stk_ss,
  input  logic [WORD_W-1:0] stk_sp,
  output logic              mem_valid,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [SEL_W-1:0]  new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic [SEL_W-1:0]  new_ss,
  output logic [WORD_W-1:0] new_sp,
  output logic [WORD_W-1:0] new_flags,
  output logic [PL_W-1:0]   new_pl
);
  import intr_pkg::*;

  typedef enum logic {ST_IDLE, ST_PUSH} state_e;
  localparam int unsigned PAD_W = WORD_W - SEL_W;

  state_e            state_q;
  slot_e             slot_q;
  logic [WORD_W-1:0] sp_q;
  logic [SEL_W-1:0]  oss_q, ocs_q, tsel_q, nss_q;
  logic [WORD_W-1:0] osp_q, ofl_q, oip_q, ec_q, toff_q;
  logic [PL_W-1:0]   tpl_q;
  logic              has_ec_q, intr_q;
  logic              done_q, err_q;

  // named events for the assertions
  logic  accept_req;
  logic  refuse_req;
  logic  push_fire;
  logic  frame_last;
  slot_e last_slot;

  assign accept_req = (state_q == ST_IDLE) && start && !reject;
  assign refuse_req = (state_q == ST_IDLE) && start && reject;
  assign push_fire  = mem_valid && mem_ready;
  assign last_slot  = has_ec_q ? SL_EC : SL_IP;
  assign frame_last = push_fire && (slot_q == last_slot);

  assign mem_valid = (state_q == ST_PUSH);
  assign busy      = (state_q == ST_PUSH);
  assign mem_addr  = push_addr(sp_q);
  assign done      = done_q;
  assign err       = err_q;

  always_comb begin
    case (slot_q)
      SL_OSS:  mem_data = {{PAD_W{1'b0}}, oss_q};
      SL_OSP:  mem_data = osp_q;
      SL_FL:   mem_data = ofl_q;
      SL_CS:   mem_data = {{PAD_W{1'b0}}, ocs_q};
      SL_IP:   mem_data = oip_q;
      default: mem_data = ec_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      slot_q    <= SL_FL;
      sp_q      <= '0;
      oss_q     <= '0;
      ocs_q     <= '0;
      tsel_q    <= '0;
      nss_q     <= '0;
      osp_q     <= '0;
      ofl_q     <= '0;
      oip_q     <= '0;
      ec_q      <= '0;
      toff_q    <= '0;
      tpl_q     <= '0;
      has_ec_q  <= 1'b0;
      intr_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      new_cs    <= '0;
      new_ip    <= '0;
      new_ss    <= '0;
      new_sp    <= '0;
      new_flags <= '0;
      new_pl    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= refuse_req;
      if (accept_req) begin
        state_q  <= ST_PUSH;
        slot_q   <= need_switch ? SL_OSS : SL_FL;
        sp_q     <= need_switch ? stk_sp : cur_sp;
        nss_q    <= need_switch ? stk_ss : cur_ss;
        oss_q    <= cur_ss;
        osp_q    <= cur_sp;
        ofl_q    <= cur_flags;
        ocs_q    <= cur_cs;
        oip_q    <= cur_ip;
        ec_q     <= err_code;
        has_ec_q <= has_err;
        intr_q   <= gate_intr;
        tsel_q   <= gate_sel;
        toff_q   <= gate_off;
        tpl_q    <= gate_pl;
      end else if (push_fire) begin
        sp_q   <= push_addr(sp_q);
        slot_q <= slot_e'(slot_q + 1'b1);
        if (frame_last) begin
          state_q   <= ST_IDLE;
          done_q    <= 1'b1;
          new_cs    <= tsel_q;
          new_ip    <= toff_q;
          new_ss    <= nss_q;
          new_sp    <= push_addr(sp_q);
          new_pl    <= tpl_q;
          new_flags <= intr_q ? clear_bit(ofl_q, IF_BIT) : ofl_q;
        end
      end
    end
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R5
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (!mem_valid || mem_addr == $past(mem_addr) - WORD_W'(4)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last |=> (done && !busy && new_cs == $past(tsel_q)));

  // R7
  if_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && intr_q) |-> !new_flags[IF_BIT]);

  // R8
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_valid && !busy && !done));

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !err);
endmodule

// File: rtl/intr_frame_seq.sv
module intr_frame_seq #(
  parameter int unsigned PL_W   = 2,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned IF_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VEC_W-1:0]  vector,
  input  logic              gate_intr,
  input  logic [SEL_W-1:0]  gate_sel,
  input  logic [WORD_W-1:0] gate_off,
  input  logic [PL_W-1:0]   gate_pl,
  input  logic              has_err,
  input  logic [WORD_W-1:0] err_code,
  input  logic [PL_W-1:0]   cur_pl,
  input  logic [SEL_W-1:0]  cur_ss,
  input  logic [WORD_W-1:0] cur_sp,
  input  logic [WORD_W-1:0] cur_flags,
  input  logic [SEL_W-1:0]  cur_cs,
  input  logic [WORD_W-1:0] cur_ip,
  input  logic              bank_we,
  input  logic [PL_W-1:0]   bank_lvl,
  input  logic [SEL_W-1:0]  bank_ss,
  input  logic [WORD_W-1:0] bank_sp,
  output logic              mem_valid,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [SEL_W-1:0]  new_cs,
  output logic [WORD_W-1:0] new_ip,
  output logic [SEL_W-1:0]  new_ss,
  output logic [WORD_W-1:0] new_sp,
  output logic [WORD_W-1:0] new_flags,
  output logic [PL_W-1:0]   new_pl
);
  logic              reject;
  logic              need_switch;
  logic [SEL_W-1:0]  stk_ss;
  logic [WORD_W-1:0] stk_sp;

  intr_gate_check #(.PL_W(PL_W), .VEC_W(VEC_W)) u_check (
    .vector      (vector),
    .cur_pl      (cur_pl),
    .tgt_pl      (gate_pl),
    .reject      (reject),
    .need_switch (need_switch)
  );

  intr_stack_bank #(.PL_W(PL_W), .SEL_W(SEL_W), .WORD_W(WORD_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bank_we),
    .wlvl  (bank_lvl),
    .wss   (bank_ss),
    .wsp   (bank_sp),
    .rlvl  (gate_pl),
    .rss   (stk_ss),
    .rsp   (stk_sp)
  );

  intr_frame_fsm #(.PL_W(PL_W), .SEL_W(SEL_W), .WORD_W(WORD_W), .IF_BIT(IF_BIT)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .reject      (reject),
    .need_switch (need_switch),
    .gate_intr   (gate_intr),
    .gate_sel    (gate_sel),
    .gate_off    (gate_off),
    .gate_pl     (gate_pl),
    .has_err     (has_err),
    .err_code    (err_code),
    .cur_ss      (cur_ss),
    .cur_sp      (cur_sp),
    .cur_flags   (cur_flags),
    .cur_cs      (cur_cs),
    .cur_ip      (cur_ip),
    .stk_ss      (stk_ss),
    .stk_sp      (stk_sp),
    .mem_valid   (mem_valid),
    .mem_addr    (mem_addr),
    .mem_data    (mem_data),
    .mem_ready   (mem_ready),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .new_cs      (new_cs),
    .new_ip      (new_ip),
    .new_ss      (new_ss),
    .new_sp      (new_sp),
    .new_flags   (new_flags),
    .new_pl      (new_pl)
  );
endmodule

// File: tb/sim_intr_frame_seq.sv
module sim_intr_frame_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  vector = '0;
  logic        gate_intr = 1'b0;
  logic [15:0] gate_sel = '0;
  logic [31:0] gate_off = '0;
  logic [1:0]  gate_pl = '0;
  logic        has_err = 1'b0;
  logic [31:0] err_code = '0;
  logic [1:0]  cur_pl = '0;
  logic [15:0] cur_ss = '0;
  logic [31:0] cur_sp = '0;
  logic [31:0] cur_flags = '0;
  logic [15:0] cur_cs = '0;
  logic [31:0] cur_ip = '0;
  logic        bank_we = 1'b0;
  logic [1:0]  bank_lvl = '0;
  logic [15:0] bank_ss = '0;
  logic [31:0] bank_sp = '0;
  logic        mem_valid;
  logic [31:0] mem_addr;
  logic [31:0] mem_data;
  logic        mem_ready = 1'b0;
  logic        busy, done, err;
  logic [15:0] new_cs, new_ss;
  logic [31:0] new_ip, new_sp, new_flags;
  logic [1:0]  new_pl;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0] bank_ss_m [4];
  logic [31:0] bank_sp_m [4];
  logic [31:0] log_a [8];
  logic [31:0] log_d [8];
  int          nlog;
  bit          saw_done, saw_err, stall_bad, done_long;

  always #4 clk = ~clk;

  intr_frame_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .vector(vector),
    .gate_intr(gate_intr), .gate_sel(gate_sel), .gate_off(gate_off),
    .gate_pl(gate_pl), .has_err(has_err), .err_code(err_code),
    .cur_pl(cur_pl), .cur_ss(cur_ss), .cur_sp(cur_sp), .cur_flags(cur_flags),
    .cur_cs(cur_cs), .cur_ip(cur_ip), .bank_we(bank_we), .bank_lvl(bank_lvl),
    .bank_ss(bank_ss), .bank_sp(bank_sp), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready),
    .busy(busy), .done(done), .err(err), .new_cs(new_cs), .new_ip(new_ip),
    .new_ss(new_ss), .new_sp(new_sp), .new_flags(new_flags), .new_pl(new_pl)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bank_write(input logic [1:0] lvl, input logic [15:0] ss,
                            input logic [31:0] sp);
    @(negedge clk);
    bank_we = 1'b1; bank_lvl = lvl; bank_ss = ss; bank_sp = sp;
    @(negedge clk);
    bank_we = 1'b0;
    bank_ss_m[lvl] = ss;
    bank_sp_m[lvl] = sp;
  endtask

  // drives one request and records the writes; stall=1 holds ready low on
  // even cycles, poke=1 raises start with a reserved vector mid-frame
  task automatic run_req(input logic [7:0] v, input bit gi, input logic [15:0] gs,
                         input logic [31:0] go, input logic [1:0] gp, input bit he,
                         input logic [31:0] ec, input logic [1:0] cp,
                         input logic [15:0] css, input logic [31:0] csp,
                         input logic [31:0] cfl, input logic [15:0] ccs,
                         input logic [31:0] cip, input bit stall, input bit poke,
                         input int maxc);
    bit prev_stall;
    logic [31:0] ha, hd;
    int cyc;
    @(negedge clk);
    vector = v; gate_intr = gi; gate_sel = gs; gate_off = go; gate_pl = gp;
    has_err = he; err_code = ec; cur_pl = cp; cur_ss = css; cur_sp = csp;
    cur_flags = cfl; cur_cs = ccs; cur_ip = cip; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble the request inputs: the block must use its captured copy
    cur_sp = 32'hDEAD_0000; cur_flags = 32'h0; cur_ip = 32'h0; err_code = 32'h0;
    nlog = 0; saw_done = 0; saw_err = err; stall_bad = 0; done_long = 0;
    prev_stall = 0; ha = '0; hd = '0;
    cyc = 0;
    while (!saw_done && cyc < maxc) begin
      if (done) begin
        saw_done = 1;
      end else begin
        if (cyc > 0 && err) saw_err = 1;
        mem_ready = stall ? ((cyc % 2) == 1) : 1'b1;
        if (mem_valid) begin
          if (prev_stall && (mem_addr != ha || mem_data != hd)) stall_bad = 1;
          if (mem_ready) begin
            if (nlog < 8) begin
              log_a[nlog] = mem_addr;
              log_d[nlog] = mem_data;
            end
            nlog++;
            prev_stall = 0;
          end else begin
            prev_stall = 1; ha = mem_addr; hd = mem_data;
          end
        end
        if (poke && cyc == 1) begin start = 1'b1; vector = 8'd15; end
        if (poke && cyc == 2) start = 1'b0;
        @(negedge clk);
        cyc++;
      end
    end
    mem_ready = 1'b0;
    start = 1'b0;
    if (saw_done) begin
      @(negedge clk);
      if (done) done_long = 1;
    end
  endtask

  task automatic check_frame(input string tag, input bit sw, input logic [31:0] base,
                             input logic [15:0] css, input logic [31:0] csp,
                             input logic [31:0] cfl, input logic [15:0] ccs,
                             input logic [31:0] cip, input bit he, input logic [31:0] ec);
    logic [31:0] exp_w [6];
    int n;
    n = 0;
    if (sw) begin
      exp_w[n] = {16'h0, css}; n++;
      exp_w[n] = csp; n++;
    end
    exp_w[n] = cfl; n++;
    exp_w[n] = {16'h0, ccs}; n++;
    exp_w[n] = cip; n++;
    if (he) begin exp_w[n] = ec; n++; end
    chk(nlog == n, {tag, " word count"}, 32'(nlog), 32'(n));
    for (int i = 0; i < n && i < nlog; i++) begin
      chk(log_a[i] == base - 32'(4 * (i + 1)), {tag, " address"}, log_a[i],
          base - 32'(4 * (i + 1)));
      chk(log_d[i] == exp_w[i], {tag, " data"}, log_d[i], exp_w[i]);
    end
    chk(new_sp == base - 32'(4 * n), "R6 new_sp", new_sp, base - 32'(4 * n));
  endtask

  task automatic t_reset;
    chk(!busy && !done && !err && !mem_valid, "R1 idle flags",
        {28'h0, busy, done, err, mem_valid}, 32'h0);
    chk(new_cs == 0 && new_ss == 0 && new_pl == 0, "R1 new selectors",
        {new_cs, new_ss}, 32'h0);
    chk(new_ip == 0 && new_sp == 0 && new_flags == 0, "R1 new words",
        new_ip | new_sp | new_flags, 32'h0);
  endtask

  task automatic t_same_trap;
    // R2: same level, trap gate, no error code, vector 33
    run_req(8'd33, 1'b0, 16'h0023, 32'h0040_1000, 2'd3, 1'b0, 32'h0, 2'd3,
            16'h002B, 32'h0001_0000, 32'h0000_0246, 16'h001B, 32'h0804_8123, 0, 0, 200);
    chk(saw_done && !saw_err, "R2 completes", {30'h0, saw_done, saw_err}, 32'h2);
    check_frame("R2", 0, 32'h0001_0000, 16'h002B, 32'h0001_0000, 32'h0000_0246,
                16'h001B, 32'h0804_8123, 0, 0);
    chk(new_flags == 32'h0000_0246, "R7 trap keeps flags", new_flags, 32'h0000_0246);
    chk(new_cs == 16'h0023 && new_ip == 32'h0040_1000, "R6 handler cs/ip",
        {16'h0, new_cs}, 32'h0023);
    chk(new_ss == 16'h002B && new_pl == 2'd3, "R6 new_ss", {16'h0, new_ss}, 32'h002B);
    chk(!done_long, "R6 done one cycle", {31'h0, done_long}, 32'h0);
  endtask

  task automatic t_same_intr_err;
    // R3 R7 R5: same level 0, interrupt gate, error code, vector 14, stalls
    run_req(8'd14, 1'b1, 16'h0008, 32'h0010_2000, 2'd0, 1'b1, 32'h0000_0006, 2'd0,
            16'h0010, 32'h0002_0000, 32'h0000_0202, 16'h0008, 32'h0010_5555, 1, 0, 200);
    chk(saw_done && !saw_err, "R3 completes", {30'h0, saw_done, saw_err}, 32'h2);
    check_frame("R3", 0, 32'h0002_0000, 16'h0010, 32'h0002_0000, 32'h0000_0202,
                16'h0008, 32'h0010_5555, 1, 32'h0000_0006);
    chk(!stall_bad, "R5 held while not ready", {31'h0, stall_bad}, 32'h0);
    chk(new_flags == 32'h0000_0002, "R7 interrupt gate clears bit 9",
        new_flags, 32'h0000_0002);
    chk(log_d[0] == 32'h0000_0202, "R7 pushed flags unmodified", log_d[0], 32'h0000_0202);
  endtask

  task automatic t_switch_err;
    // R4 R11: level 3 -> 0 with error code, interrupt gate, vector 13
    bank_write(2'd0, 16'h0018, 32'h0000_9000);
    run_req(8'd13, 1'b1, 16'h0010, 32'h00C0_0100, 2'd0, 1'b1, 32'h0000_0ABC, 2'd3,
            16'h002B, 32'h7FFF_F000, 32'h0000_0297, 16'h0023, 32'h0040_0ABC, 0, 0, 200);
    chk(saw_done && !saw_err, "R4 completes", {30'h0, saw_done, saw_err}, 32'h2);
    check_frame("R4", 1, bank_sp_m[0], 16'h002B, 32'h7FFF_F000, 32'h0000_0297,
                16'h0023, 32'h0040_0ABC, 1, 32'h0000_0ABC);
    chk(new_ss == bank_ss_m[0], "R11 new_ss from bank", {16'h0, new_ss},
        {16'h0, bank_ss_m[0]});
    chk(new_flags == 32'h0000_0097, "R7 switch flags", new_flags, 32'h0000_0097);
    chk(new_pl == 2'd0, "R6 new_pl", {30'h0, new_pl}, 32'h0);
  endtask

  task automatic t_switch_poke;
    // R4 R10 R8: level 2 -> 1, trap, vector 255, stalls, mid-frame start
    bank_write(2'd1, 16'h0031, 32'h0003_4000);
    bank_write(2'd1, 16'h0039, 32'h0004_8000);
    run_req(8'd255, 1'b0, 16'h0041, 32'h0000_7777, 2'd1, 1'b0, 32'h0, 2'd2,
            16'h0051, 32'h0005_0000, 32'h0000_0202, 16'h0049, 32'h0000_1234, 1, 1, 200);
    chk(saw_done && !saw_err, "R10 start while busy ignored",
        {30'h0, saw_done, saw_err}, 32'h2);
    check_frame("R10", 1, 32'h0004_8000, 16'h0051, 32'h0005_0000, 32'h0000_0202,
                16'h0049, 32'h0000_1234, 0, 0);
    chk(new_ss == 16'h0039, "R11 last bank write wins", {16'h0, new_ss}, 32'h0039);
    chk(new_flags == 32'h0000_0202, "R7 trap switch flags", new_flags, 32'h0000_0202);
  endtask

  task automatic t_refuse(input logic [7:0] v, input logic [1:0] gp,
                          input logic [1:0] cp, input string tag);
    logic [31:0] ncs_before;
    ncs_before = {16'h0, new_cs};
    run_req(v, 1'b1, 16'h0777, 32'h0000_0999, gp, 1'b0, 32'h0, cp,
            16'h0010, 32'h0006_0000, 32'h0000_0202, 16'h0008, 32'h0000_0010, 0, 0, 6);
    chk(saw_err && nlog == 0 && !saw_done, {tag, " refused"},
        {16'h0, 8'(nlog), 6'h0, saw_err, saw_done}, 32'h2);
    chk({16'h0, new_cs} == ncs_before, {tag, " state unchanged"},
        {16'h0, new_cs}, ncs_before);
    chk(!busy && !err, {tag, " err one cycle"}, {30'h0, busy, err}, 32'h0);
  endtask

  task automatic t_edge_vectors;
    // R8: 16 and 32 sit next to reserved ranges and are accepted
    run_req(8'd16, 1'b0, 16'h0008, 32'h0000_0100, 2'd0, 1'b0, 32'h0, 2'd0,
            16'h0010, 32'h0007_0000, 32'h0, 16'h0008, 32'h0000_0020, 0, 0, 200);
    chk(saw_done && !saw_err && nlog == 3, "R8 vector 16 accepted",
        32'(nlog), 32'd3);
    run_req(8'd32, 1'b0, 16'h0008, 32'h0000_0100, 2'd0, 1'b0, 32'h0, 2'd0,
            16'h0010, 32'h0007_0000, 32'h0, 16'h0008, 32'h0000_0020, 0, 0, 200);
    chk(saw_done && !saw_err && nlog == 3, "R8 vector 32 accepted",
        32'(nlog), 32'd3);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin bank_ss_m[i] = '0; bank_sp_m[i] = '0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_same_trap();
    t_same_intr_err();
    t_switch_err();
    t_switch_poke();
    t_refuse(8'd15, 2'd0, 2'd0, "R8 vector 15");
    t_refuse(8'd20, 2'd0, 2'd0, "R8 vector 20");
    t_refuse(8'd31, 2'd1, 2'd1, "R8 vector 31");
    t_refuse(8'd40, 2'd2, 2'd0, "R9 less privileged");
    t_edge_vectors();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule